// File: doc/BRIEF.md
# Descriptor-Driven Cipher Job Controller

This block is the control front end of a memory-mapped cipher accelerator. Software places an eight-word job descriptor in a small local RAM, writes the descriptor's byte offset into a pointer register, and sets the run bit in a command register. The controller reads the descriptor back from the RAM and decodes the configuration word: operation, cipher, direction, chaining mode, triple-DES variant and AES key size. It also takes the source, destination, key and IV offsets and the byte count. These are handed to a cipher datapath through a single-cycle start pulse, and the controller then waits for the datapath's done pulse.

When the job ends, completion flags are set in an interrupt status register. Software clears a flag by writing 0 to its bit. A write to the legacy alias address has the same effect as a write to the main status address. The interrupt line is the OR of the status bits that the mask register enables. A configuration word that the datapath cannot run completes the job at once, without starting the datapath.

Top module: `cipher_desc_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `dp_start` is 0.
- R2: Writing 1 to command bit 0 (register 0xDE00) while idle fetches eight words from RAM word address pointer[AW+1:2] onwards and gives exactly one single-cycle `dp_start`. Word 1 gives src (bits 15:0) and dst (bits 31:16). Word 2 gives the length. Word 3 bits 15:0 give the key offset. Word 4 gives IV-in (bits 15:0) and IV-out (bits 31:16).
- R3: The descriptor's word 0 is decoded as follows, and the result is presented on the `dp_*` mode outputs: bits 1:0 operation, bits 9:8 cipher (1 DES, 2 3DES, 3 AES), bit 12 decrypt, bit 16 CBC, bit 20 EDE, bits 25:24 AES key size (0/1/2 = 128/192/256).
- R4: Status register 0xDE0C bit 0 and command bit 0 both read 1 from an accepted start until the job completes, and both read 0 afterwards.
- R5: When the datapath reports done, interrupt status (0xDE20) sets bit 5 (channel done) and bit 4 (cipher done). It also sets bit 2 for an AES encrypt, bit 3 for an AES decrypt, and bit 1 for DES or 3DES.
- R6: A write to 0xDE20 or to its alias 0xDD68 clears each status bit written 0 and keeps each bit written 1. Both addresses read the same value.
- R7: `irq` is the OR of the interrupt status bits ANDed with the mask register (0xDE24, bits 6:0). `irq` is registered, so it follows the status one cycle later.
- R8: A command write with bit 0 set while a job is active is ignored. No second start is given and no second fetch takes place.
- R9: A command write with bit 2 (disable) set starts nothing, even if bit 0 is set. Bit 2 reads back.
- R10: A descriptor whose operation is not 1 (cipher only), whose cipher is 0, or that asks for AES with key size 3 completes with only status bit 5 set, and `dp_start` is never raised.
- R11: Configuration register 0xDE08 bit 0 and the full 32-bit descriptor pointer at 0xDE04 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe, data returned next cycle |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ram_we | input | 1 | Descriptor RAM write strobe |
| ram_addr | input | AW | Descriptor RAM word address |
| ram_wdata | input | 32 | Descriptor RAM write data |
| dp_start | output | 1 | Single-cycle job start to datapath |
| dp_src | output | 16 | Source byte offset |
| dp_dst | output | 16 | Destination byte offset |
| dp_key | output | 16 | Key byte offset |
| dp_iv_in | output | 16 | IV input offset |
| dp_iv_out | output | 16 | IV output buffer offset |
| dp_len | output | LEN_W | Byte count |
| dp_cipher | output | 2 | Cipher select |
| dp_decrypt | output | 1 | Direction, 1 = decrypt |
| dp_cbc | output | 1 | 1 = CBC, 0 = ECB |
| dp_ede | output | 1 | 3DES EDE variant |
| dp_keylen | output | 2 | AES key size code |
| dp_done | input | 1 | Datapath completion pulse |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench builds the block with AW = 5, which gives a 32-word RAM. This small size lets one descriptor sit in the last eight words, so the fetch reaches the highest RAM addresses. LEN_W keeps its default of 16. The datapath stub waits 20 cycles before it answers. That window is long enough for the status reads and for a second, rejected command write to land while a job is still running.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  localparam logic [15:0] A_CMD    = 16'hDE00;
  localparam logic [15:0] A_DPTR   = 16'hDE04;
  localparam logic [15:0] A_CFG    = 16'hDE08;
  localparam logic [15:0] A_STAT   = 16'hDE0C;
  localparam logic [15:0] A_IST    = 16'hDE20;
  localparam logic [15:0] A_IMSK   = 16'hDE24;
  localparam logic [15:0] A_IST_AL = 16'hDD68;

  localparam int IST_W      = 7;
  localparam int IB_DES     = 1;
  localparam int IB_AES_ENC = 2;
  localparam int IB_AES_DEC = 3;
  localparam int IB_CRYPT   = 4;
  localparam int IB_CH0     = 5;

  localparam int DESC_WORDS = 8;
  localparam int OFS_W      = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_RUN, S_FINISH
  } seq_state_t;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] cipher;
    logic       dec;
    logic       cbc;
    logic       ede;
    logic [1:0] klen;
  } mode_t;

  function automatic mode_t decode_mode(input logic [31:0] w);
    mode_t m;
    m.op     = w[1:0];
    m.cipher = w[9:8];
    m.dec    = w[12];
    m.cbc    = w[16];
    m.ede    = w[20];
    m.klen   = w[25:24];
    return m;
  endfunction

  function automatic logic mode_ok(input mode_t m);
    return (m.op == 2'd1) && (m.cipher != 2'd0) &&
           !((m.cipher == 2'd3) && (m.klen == 2'd3));
  endfunction

  function automatic logic [IST_W-1:0] run_flags(input mode_t m);
    logic [IST_W-1:0] f;
    f = '0;
    f[IB_CH0]     = 1'b1;
    f[IB_CRYPT]   = 1'b1;
    f[IB_AES_ENC] = (m.cipher == 2'd3) && !m.dec;
    f[IB_AES_DEC] = (m.cipher == 2'd3) && m.dec;
    f[IB_DES]     = (m.cipher == 2'd1) || (m.cipher == 2'd2);
    return f;
  endfunction
endpackage

// File: rtl/cdc_sram.sv
module cdc_sram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cdc_regs.sv
module cdc_regs
  import cdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [15:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             fin,
  input  logic [IST_W-1:0] fin_flags,
  output logic             start_req,
  output logic [31:0]      desc_ptr,
  output logic             go,
  output logic [IST_W-1:0] ist,
  output logic [IST_W-1:0] imsk,
  output logic             irq
);
  logic             dis_q;
  logic             cfg_stop_q;
  logic             hit_cmd, hit_dptr, hit_cfg, hit_imsk, hit_ack;
  logic             launch;
  logic [IST_W-1:0] ist_nxt;

  assign hit_cmd  = bus_we && (bus_addr == A_CMD);
  assign hit_dptr = bus_we && (bus_addr == A_DPTR);
  assign hit_cfg  = bus_we && (bus_addr == A_CFG);
  assign hit_imsk = bus_we && (bus_addr == A_IMSK);
  assign hit_ack  = bus_we && ((bus_addr == A_IST) || (bus_addr == A_IST_AL));

  assign launch = hit_cmd && bus_wdata[0] && !bus_wdata[2] && !go;

  always_comb begin
    ist_nxt = ist;
    if (hit_ack) ist_nxt = ist_nxt & bus_wdata[IST_W-1:0];
    if (fin)     ist_nxt = ist_nxt | fin_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q      <= 1'b0;
      go         <= 1'b0;
      start_req  <= 1'b0;
      desc_ptr   <= '0;
      cfg_stop_q <= 1'b0;
      imsk       <= '0;
      ist        <= '0;
      irq        <= 1'b0;
    end else begin
      if (hit_cmd) dis_q <= bus_wdata[2];
      if (launch)   go <= 1'b1;
      else if (fin) go <= 1'b0;
      start_req <= launch;
      if (hit_dptr) desc_ptr   <= bus_wdata;
      if (hit_cfg)  cfg_stop_q <= bus_wdata[0];
      if (hit_imsk) imsk       <= bus_wdata[IST_W-1:0];
      ist <= ist_nxt;
      irq <= |(ist & imsk);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        A_CMD:             bus_rdata <= {29'd0, dis_q, 1'b0, go};
        A_DPTR:            bus_rdata <= desc_ptr;
        A_CFG:             bus_rdata <= {31'd0, cfg_stop_q};
        A_STAT:            bus_rdata <= {31'd0, go};
        A_IST, A_IST_AL:   bus_rdata <= {{(32-IST_W){1'b0}}, ist};
        A_IMSK:            bus_rdata <= {{(32-IST_W){1'b0}}, imsk};
        default:           bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cdc_seq.sv
module cdc_seq
  import cdc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [AW-1:0]    desc_base,
  output logic             sram_re,
  output logic [AW-1:0]    sram_raddr,
  input  logic [31:0]      sram_rdata,
  output logic             dp_start,
  output logic [OFS_W-1:0] dp_src,
  output logic [OFS_W-1:0] dp_dst,
  output logic [OFS_W-1:0] dp_key,
  output logic [OFS_W-1:0] dp_iv_in,
  output logic [OFS_W-1:0] dp_iv_out,
  output logic [LEN_W-1:0] dp_len,
  output mode_t            dp_mode,
  input  logic             dp_done,
  output logic             fin,
  output logic [IST_W-1:0] fin_flags
);
  localparam int IDX_W = $clog2(DESC_WORDS) + 1;

  seq_state_t       state;
  logic [AW-1:0]    base;
  logic [IDX_W-1:0] iss_idx;
  logic             cap_vld;
  logic [IDX_W-2:0] cap_idx;

  assign sram_re    = (state == S_FETCH) && !iss_idx[IDX_W-1];
  assign sram_raddr = base + AW'(iss_idx[IDX_W-2:0]);
  assign fin        = (state == S_FINISH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      base      <= '0;
      iss_idx   <= '0;
      cap_vld   <= 1'b0;
      cap_idx   <= '0;
      dp_start  <= 1'b0;
      dp_src    <= '0;
      dp_dst    <= '0;
      dp_key    <= '0;
      dp_iv_in  <= '0;
      dp_iv_out <= '0;
      dp_len    <= '0;
      dp_mode   <= '0;
      fin_flags <= '0;
    end else begin
      cap_vld <= sram_re;
      cap_idx <= iss_idx[IDX_W-2:0];
      if (sram_re) iss_idx <= iss_idx + 1'b1;

      if (cap_vld) begin
        case (cap_idx)
          3'd0: dp_mode <= decode_mode(sram_rdata);
          3'd1: begin
            dp_src <= sram_rdata[15:0];
            dp_dst <= sram_rdata[31:16];
          end
          3'd2: dp_len <= sram_rdata[LEN_W-1:0];
          3'd3: dp_key <= sram_rdata[15:0];
          3'd4: begin
            dp_iv_in  <= sram_rdata[15:0];
            dp_iv_out <= sram_rdata[31:16];
          end
          default: ;
        endcase
      end

      case (state)
        S_IDLE: begin
          if (start_req) begin
            base    <= desc_base;
            iss_idx <= '0;
            state   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (cap_vld && (cap_idx == IDX_W'(DESC_WORDS - 1))) state <= S_DECODE;
        end
        S_DECODE: begin
          if (mode_ok(dp_mode)) begin
            dp_start <= 1'b1;
            state    <= S_RUN;
          end else begin
            fin_flags         <= '0;
            fin_flags[IB_CH0] <= 1'b1;
            state             <= S_FINISH;
          end
        end
        S_RUN: begin
          dp_start <= 1'b0;
          if (dp_done && !dp_start) begin
            fin_flags <= run_flags(dp_mode);
            state     <= S_FINISH;
          end
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cipher_desc_ctrl.sv
module cipher_desc_ctrl
  import cdc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [15:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ram_we,
  input  logic [AW-1:0]    ram_addr,
  input  logic [31:0]      ram_wdata,
  output logic             dp_start,
  output logic [15:0]      dp_src,
  output logic [15:0]      dp_dst,
  output logic [15:0]      dp_key,
  output logic [15:0]      dp_iv_in,
  output logic [15:0]      dp_iv_out,
  output logic [LEN_W-1:0] dp_len,
  output logic [1:0]       dp_cipher,
  output logic             dp_decrypt,
  output logic             dp_cbc,
  output logic             dp_ede,
  output logic [1:0]       dp_keylen,
  input  logic             dp_done,
  output logic             irq
);
  logic             start_req_w, go_w, fin_w;
  logic [31:0]      desc_ptr_w;
  logic [IST_W-1:0] ist_w, imsk_w, fin_flags_w;
  logic             sram_re_w;
  logic [AW-1:0]    sram_raddr_w;
  logic [31:0]      sram_rdata_w;
  mode_t            mode_w;

  cdc_sram #(.AW(AW), .DW(32)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
    .re(sram_re_w), .raddr(sram_raddr_w), .rdata(sram_rdata_w)
  );

  cdc_regs u_regs (
    .clk(clk), .rst(rst),
    .bus_we(reg_we), .bus_re(reg_re), .bus_addr(reg_addr),
    .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .fin(fin_w), .fin_flags(fin_flags_w),
    .start_req(start_req_w), .desc_ptr(desc_ptr_w), .go(go_w),
    .ist(ist_w), .imsk(imsk_w), .irq(irq)
  );

  cdc_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst),
    .start_req(start_req_w), .desc_base(desc_ptr_w[AW+1:2]),
    .sram_re(sram_re_w), .sram_raddr(sram_raddr_w), .sram_rdata(sram_rdata_w),
    .dp_start(dp_start), .dp_src(dp_src), .dp_dst(dp_dst), .dp_key(dp_key),
    .dp_iv_in(dp_iv_in), .dp_iv_out(dp_iv_out), .dp_len(dp_len),
    .dp_mode(mode_w), .dp_done(dp_done),
    .fin(fin_w), .fin_flags(fin_flags_w)
  );

  assign dp_cipher  = mode_w.cipher;
  assign dp_decrypt = mode_w.dec;
  assign dp_cbc     = mode_w.cbc;
  assign dp_ede     = mode_w.ede;
  assign dp_keylen  = mode_w.klen;
endmodule

// File: rtl/cdc_chk.sv
module cdc_chk #(
  parameter int IST_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             dp_start,
  input logic             fin,
  input logic             go,
  input logic [IST_W-1:0] ist,
  input logic [IST_W-1:0] imsk,
  input logic             irq
);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    dp_start |=> !dp_start);

  p_start_active_r4: assert property (@(posedge clk) disable iff (rst)
    dp_start |-> go);

  p_go_clears_r4: assert property (@(posedge clk) disable iff (rst)
    fin |=> !go);

  p_done_flag_r5: assert property (@(posedge clk) disable iff (rst)
    fin |=> ist[5]);

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(imsk) != '0));
endmodule

bind cipher_desc_ctrl cdc_chk #(.IST_W(cdc_pkg::IST_W)) u_chk (
  .clk(clk), .rst(rst), .dp_start(dp_start), .fin(fin_w), .go(go_w),
  .ist(ist_w), .imsk(imsk_w), .irq(irq)
);

// File: tb/sim_cipher_desc_ctrl.sv
module sim_cipher_desc_ctrl;
  localparam int AW = 5;
  localparam int LEN_W = 16;
  localparam int DP_LAT = 20;

  typedef struct packed {
    logic [15:0] src, dst, key, ivi, ivo, len;
    logic [1:0]  cipher;
    logic        dec, cbc, ede;
    logic [1:0]  kl;
  } job_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 0, reg_re = 0, ram_we = 0, dp_done = 0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, ram_wdata = '0;
  logic [AW-1:0] ram_addr = '0;
  logic [31:0] reg_rdata;
  logic dp_start, dp_decrypt, dp_cbc, dp_ede, irq;
  logic [15:0] dp_src, dp_dst, dp_key, dp_iv_in, dp_iv_out;
  logic [LEN_W-1:0] dp_len;
  logic [1:0] dp_cipher, dp_keylen;

  int checks = 0, errors = 0, n_starts = 0;
  bit finished = 0;
  job_t exp_q[$];

  always #4 clk = ~clk;

  cipher_desc_ctrl #(.AW(AW), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .dp_start(dp_start),
    .dp_src(dp_src), .dp_dst(dp_dst), .dp_key(dp_key), .dp_iv_in(dp_iv_in),
    .dp_iv_out(dp_iv_out), .dp_len(dp_len), .dp_cipher(dp_cipher),
    .dp_decrypt(dp_decrypt), .dp_cbc(dp_cbc), .dp_ede(dp_ede),
    .dp_keylen(dp_keylen), .dp_done(dp_done), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_re = 0;
  endtask

  task automatic put_desc(input int wb, input logic [31:0] cfg, input logic [31:0] pw,
                          input logic [31:0] lw, input logic [31:0] kw, input logic [31:0] iw);
    logic [31:0] w [8];
    w[0] = cfg; w[1] = pw; w[2] = lw; w[3] = kw; w[4] = iw;
    w[5] = 32'hA5A5_0005; w[6] = 32'hA5A5_0006; w[7] = 32'hA5A5_0007;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ram_we = 1; ram_addr = AW'(wb + i); ram_wdata = w[i];
    end
    @(negedge clk);
    ram_we = 0;
  endtask

  function automatic job_t mk_job(input logic [31:0] cfg, input logic [31:0] pw,
                                  input logic [31:0] lw, input logic [31:0] kw, input logic [31:0] iw);
    job_t j;
    j.src = pw[15:0]; j.dst = pw[31:16]; j.len = lw[15:0]; j.key = kw[15:0];
    j.ivi = iw[15:0]; j.ivo = iw[31:16];
    j.cipher = cfg[9:8]; j.dec = cfg[12]; j.cbc = cfg[16]; j.ede = cfg[20]; j.kl = cfg[25:24];
    return j;
  endfunction

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      reg_read(16'hDE0C, d);
      if (d[0] == 1'b0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_job(input int wb, input logic [31:0] cfg, input logic [31:0] pw,
                         input logic [31:0] lw, input logic [31:0] kw, input logic [31:0] iw,
                         input bit expect_start);
    put_desc(wb, cfg, pw, lw, kw, iw);
    if (expect_start) exp_q.push_back(mk_job(cfg, pw, lw, kw, iw));
    reg_write(16'hDE04, 32'(wb * 4));
    reg_write(16'hDE00, 32'h1);
    wait_idle();
  endtask

  // Datapath stub: answers each start after DP_LAT cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (dp_start) begin
        repeat (DP_LAT) @(negedge clk);
        dp_done = 1;
        @(negedge clk);
        dp_done = 0;
      end
    end
  end

  // Scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && dp_start) begin
        job_t got, exp;
        n_starts++;
        got = {dp_src, dp_dst, dp_key, dp_iv_in, dp_iv_out, dp_len,
               dp_cipher, dp_decrypt, dp_cbc, dp_ede, dp_keylen};
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected dp_start", 1, 0);
        end else begin
          exp = exp_q.pop_front();
          check(got == exp, "R2/R3 job fields", got, exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int s0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    reg_read(16'hDE00, d); check(d == 0, "R1 cmd", d, 0);
    reg_read(16'hDE0C, d); check(d == 0, "R1 stat", d, 0);
    reg_read(16'hDE20, d); check(d == 0, "R1 ist", d, 0);
    reg_read(16'hDE24, d); check(d == 0, "R1 mask", d, 0);
    check(irq == 0 && dp_start == 0, "R1 outputs", {irq, dp_start}, 0);

    // R2 R3 R5: AES-128 ECB encrypt
    run_job(0, 32'h0000_0301, 32'h0200_0100, 32'h0000_0040, 32'h0000_0020, 32'h0050_0040, 1);
    reg_read(16'hDE20, d); check(d == 32'h34, "R5 aes enc flags", d, 32'h34);
    check(irq == 0, "R7 irq masked off", irq, 0);

    // R7 mask, R6 clear and alias
    reg_write(16'hDE24, 32'h20);
    repeat (2) @(negedge clk);
    check(irq == 1, "R7 irq with mask", irq, 1);
    reg_write(16'hDE20, 32'h14);
    reg_read(16'hDE20, d); check(d == 32'h14, "R6 write-zero clear", d, 32'h14);
    repeat (2) @(negedge clk);
    check(irq == 0, "R7 irq after ack", irq, 0);
    reg_write(16'hDD68, 32'h14);
    reg_read(16'hDD68, d); check(d == 32'h14, "R6 alias same ack", d, 32'h14);
    reg_write(16'hDD68, 32'h0);
    reg_read(16'hDE20, d); check(d == 0, "R6 alias clears", d, 0);

    // R3 R4 R8: AES-256 CBC decrypt at top of RAM, second start ignored
    put_desc(24, 32'h0201_1301, 32'h0333_0111, 32'h0000_0100, 32'h0000_0060, 32'h0070_0068);
    exp_q.push_back(mk_job(32'h0201_1301, 32'h0333_0111, 32'h0000_0100, 32'h0000_0060, 32'h0070_0068));
    s0 = n_starts;
    reg_write(16'hDE04, 32'h60);
    reg_write(16'hDE00, 32'h1);
    reg_read(16'hDE0C, d); check(d == 1, "R4 stat active", d, 1);
    reg_read(16'hDE00, d); check(d == 1, "R4 cmd bit set", d, 1);
    reg_write(16'hDE04, 32'h0);
    reg_write(16'hDE00, 32'h1);
    wait_idle();
    check(n_starts == s0 + 1, "R8 one start only", n_starts - s0, 1);
    reg_read(16'hDE00, d); check(d == 0, "R4 cmd self-clear", d, 0);
    reg_read(16'hDE20, d); check(d == 32'h38, "R5 aes dec flags", d, 32'h38);
    reg_write(16'hDE20, 32'h0);

    // R3 R5: 3DES CBC EDE encrypt, DES ECB decrypt
    run_job(8, 32'h0011_0201, 32'h0010_0008, 32'h0000_0018, 32'h0000_0030, 32'h0044_0040, 1);
    reg_read(16'hDE20, d); check(d == 32'h32, "R5 3des flags", d, 32'h32);
    reg_write(16'hDE20, 32'h0);
    run_job(16, 32'h0300_1101, 32'h0004_0002, 32'h0000_0008, 32'h0000_0010, 32'h0000_0000, 1);
    reg_read(16'hDE20, d); check(d == 32'h32, "R5 des flags", d, 32'h32);
    reg_write(16'hDE20, 32'h0);

    // R10 unsupported encodings
    s0 = n_starts;
    run_job(0, 32'h0000_0350, 32'h1, 32'h10, 32'h0, 32'h0, 0);
    reg_read(16'hDE20, d); check(d == 32'h20, "R10 mac op", d, 32'h20);
    reg_write(16'hDE20, 32'h0);
    run_job(8, 32'h0300_0301, 32'h1, 32'h10, 32'h0, 32'h0, 0);
    reg_read(16'hDE20, d); check(d == 32'h20, "R10 aes keysize 3", d, 32'h20);
    reg_write(16'hDE20, 32'h0);
    run_job(16, 32'h0000_0001, 32'h1, 32'h10, 32'h0, 32'h0, 0);
    reg_read(16'hDE20, d); check(d == 32'h20, "R10 no cipher", d, 32'h20);
    reg_write(16'hDE20, 32'h0);
    check(n_starts == s0, "R10 no dp_start", n_starts - s0, 0);

    // R9 disable
    s0 = n_starts;
    reg_write(16'hDE04, 32'h0);
    reg_write(16'hDE00, 32'h5);
    repeat (30) @(negedge clk);
    reg_read(16'hDE0C, d); check(d == 0, "R9 no start", d, 0);
    reg_read(16'hDE00, d); check(d == 32'h4, "R9 disable readback", d, 32'h4);
    reg_read(16'hDE20, d); check(d == 0, "R9 no completion", d, 0);
    check(n_starts == s0, "R9 no dp_start", n_starts - s0, 0);

    // R11 readback
    reg_write(16'hDE08, 32'h1);
    reg_read(16'hDE08, d); check(d == 1, "R11 cfg", d, 1);
    reg_write(16'hDE04, 32'hCAFE_0040);
    reg_read(16'hDE04, d); check(d == 32'hCAFE_0040, "R11 pointer", d, 32'hCAFE_0040);

    check(exp_q.size() == 0, "R2 all jobs started", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule